// File: doc/BRIEF.md
# Microcoded Memory Strobe Phase Generator

This block turns one 32-bit control word per memory-clock cycle into the levels of the external memory strobes: one chip-select, four byte-selects and three general-purpose lines, all active-low. The memory-clock cycle is divided into four quarter-phases, and a phase code at the input says which quarter is being produced. For each strobe and quarter, dedicated timing bits in the word choose assert or negate. Bits are numbered from the MSB, so word bit k is `word[31-k]`.

Byte-selects are further qualified by the access: the port width, the transfer length and the low address bits select which byte lanes may assert. The first general-purpose line has 2-bit fields that can assert it, negate it, copy a chosen address bit onto it, or hold its last level. When no access is in progress every strobe is held negated. All outputs are registered, so each input set is seen on the pins one clock later.

Top module: `strobe_phase_gen`

## Requirements
- R1: A clock edge with `rst` high leaves `cs_n`, every `bs_n` bit and every `gpl_n` bit at 1.
- R2: With `active` high and phase code p (0..3 = quarters 1..4), `cs_n` after the next edge equals word bit p, that is `word[31-p]` (0 = asserted).
- R3: For an enabled byte lane, `bs_n[i]` after the next edge equals word bit 4+p, that is `word[27-p]`.
- R4: Lane enables: `port_size` 0 = 4 lanes, 1 = 2 lanes (0..1), 2 = 1 lane (0), 3 = 4 lanes. The start lane is `addr_lo` modulo the lane count. `xfer_size` code n enables n+1 consecutive lanes, clipped at the port width. A lane that is not enabled stays at 1. `bs_n[0]` is byte offset 0.
- R5: `gpl_n[0]` uses word bits 8..9 (`word[23:22]`) in quarters 1..3 and word bits 10..11 (`word[21:20]`) in quarter 4. Code 2'b10 gives 0, code 2'b11 gives 1, and code 2'b00 gives the level of `gpl_addr_bit`.
- R6: GPL0 code 2'b01 keeps `gpl_n[0]` at its previous level.
- R7: `gpl_n[1]` takes word bit 12 (`word[19]`) in quarters 1..3 and word bit 13 (`word[18]`) in quarter 4. `gpl_n[2]` takes word bit 14 (`word[17]`) and word bit 15 (`word[16]`) in the same way.
- R8: With `active` low, all outputs are 1 after the next edge, whatever the word.
- R9: Outputs are registered: each change on the pins follows the input change by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; one edge per quarter-phase |
| rst | input | 1 | Synchronous active-high reset |
| active | input | 1 | An access is in progress |
| phase | input | 2 | Quarter-phase code, 0..3 |
| word | input | 32 | Current control word |
| port_size | input | 2 | Port width code |
| xfer_size | input | 2 | Transfer length code (bytes minus one) |
| addr_lo | input | 2 | Low address bits of the access |
| gpl_addr_bit | input | 1 | Address bit that GPL0 code 00 copies |
| cs_n | output | 1 | Chip-select, active-low |
| bs_n | output | 4 | Byte-selects, active-low, index = byte lane |
| gpl_n | output | 3 | General-purpose lines, active-low |

## Verification
The hardest situations to reach are misaligned accesses whose lanes run past the port width, and the GPL0 hold code. A hold only means something relative to a level set by an earlier quarter, and the bench must show that it keeps that level through a quarter boundary and after idle cycles. The stimulus sweeps every combination of port width, transfer length and start offset. It then chains GPL0 codes on purpose (assert then hold, negate then hold, address copy with both address levels). A long random run with occasional idle and reset cycles follows, and a behavioural model is compared on every clock.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int WORD_W = 32;
  // Field positions, MSB-numbered (bit k lives at word[WORD_W-1-k])
  localparam int CS_K0  = 0;
  localparam int BS_K0  = 4;
  localparam int G0A_K  = 8;
  localparam int G0B_K  = 10;
  localparam int G1A_K  = 12;
  localparam int G1B_K  = 13;
  localparam int G2A_K  = 14;
  localparam int G2B_K  = 15;

  typedef enum logic [1:0] {
    PW_FULL = 2'd0,
    PW_HALF = 2'd1,
    PW_BYTE = 2'd2,
    PW_RSV  = 2'd3
  } port_w_e;

  typedef enum logic [1:0] {
    G0_ADDR = 2'b00,
    G0_HOLD = 2'b01,
    G0_ASRT = 2'b10,
    G0_NEG  = 2'b11
  } g0_code_e;

  function automatic int widx(input int k);
    return WORD_W - 1 - k;
  endfunction
endpackage

// File: rtl/lane_enable_dec.sv
module lane_enable_dec
  import strobe_pkg::*;
#(
  parameter int LANES = 4,
  localparam int AW = $clog2(LANES),
  localparam int CW = AW + 1
) (
  input  logic [1:0]       port_size,
  input  logic [AW-1:0]    xfer_size,
  input  logic [AW-1:0]    addr_lo,
  output logic [LANES-1:0] lane_en
);
  logic [CW-1:0] width;
  logic [CW-1:0] start;
  logic [CW-1:0] cnt;

  always_comb begin
    unique case (port_w_e'(port_size))
      PW_HALF: width = CW'(LANES / 2);
      PW_BYTE: width = CW'(1);
      default: width = CW'(LANES);
    endcase
    start = CW'(addr_lo) & (width - CW'(1));
    cnt   = CW'(xfer_size) + CW'(1);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = (CW'(i) < width) && (CW'(i) >= start) &&
                        (CW'(i) < start + cnt);
  end
endmodule

// File: rtl/phase_field_sel.sv
module phase_field_sel
  import strobe_pkg::*;
(
  input  logic [1:0]        phase,
  input  logic [WORD_W-1:0] word,
  output logic              cs_lvl,
  output logic              bs_lvl,
  output logic [1:0]        g0_code,
  output logic              g1_lvl,
  output logic              g2_lvl
);
  logic last_q;
  logic unused_low;

  assign last_q     = (phase == 2'd3);
  assign unused_low = ^word[widx(G2B_K)-1:0];

  always_comb begin
    unique case (phase)
      2'd0: begin cs_lvl = word[widx(CS_K0)];     bs_lvl = word[widx(BS_K0)];     end
      2'd1: begin cs_lvl = word[widx(CS_K0 + 1)]; bs_lvl = word[widx(BS_K0 + 1)]; end
      2'd2: begin cs_lvl = word[widx(CS_K0 + 2)]; bs_lvl = word[widx(BS_K0 + 2)]; end
      default: begin cs_lvl = word[widx(CS_K0 + 3)]; bs_lvl = word[widx(BS_K0 + 3)]; end
    endcase
  end

  assign g0_code = last_q ? word[widx(G0B_K) -: 2] : word[widx(G0A_K) -: 2];
  assign g1_lvl  = last_q ? word[widx(G1B_K)] : word[widx(G1A_K)];
  assign g2_lvl  = last_q ? word[widx(G2B_K)] : word[widx(G2A_K)];
endmodule

// File: rtl/strobe_out_reg.sv
module strobe_out_reg
  import strobe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             cs_lvl,
  input  logic             bs_lvl,
  input  logic [LANES-1:0] lane_en,
  input  logic [1:0]       g0_code,
  input  logic             g0_addr,
  input  logic             g1_lvl,
  input  logic             g2_lvl,
  output logic             cs_n,
  output logic [LANES-1:0] bs_n,
  output logic [2:0]       gpl_n
);
  logic g0_next;

  always_comb begin
    unique case (g0_code_e'(g0_code))
      G0_ASRT: g0_next = 1'b0;
      G0_NEG:  g0_next = 1'b1;
      G0_ADDR: g0_next = g0_addr;
      default: g0_next = gpl_n[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cs_n  <= 1'b1;
      gpl_n <= '1;
    end else begin
      cs_n  <= cs_lvl;
      gpl_n <= {g2_lvl, g1_lvl, g0_next};
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_bs
    always_ff @(posedge clk) begin
      if (rst || !active) bs_n[i] <= 1'b1;
      else                bs_n[i] <= lane_en[i] ? bs_lvl : 1'b1;
    end
  end
endmodule

// File: rtl/strobe_phase_gen.sv
module strobe_phase_gen
  import strobe_pkg::*;
#(
  parameter int LANES = 4,
  localparam int AW = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [1:0]        phase,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        port_size,
  input  logic [AW-1:0]     xfer_size,
  input  logic [AW-1:0]     addr_lo,
  input  logic              gpl_addr_bit,
  output logic              cs_n,
  output logic [LANES-1:0]  bs_n,
  output logic [2:0]        gpl_n
);
  logic             cs_lvl, bs_lvl, g1_lvl, g2_lvl;
  logic [1:0]       g0_code;
  logic [LANES-1:0] lane_en;

  phase_field_sel u_sel (
    .phase(phase), .word(word), .cs_lvl(cs_lvl), .bs_lvl(bs_lvl),
    .g0_code(g0_code), .g1_lvl(g1_lvl), .g2_lvl(g2_lvl)
  );

  lane_enable_dec #(.LANES(LANES)) u_lane (
    .port_size(port_size), .xfer_size(xfer_size), .addr_lo(addr_lo),
    .lane_en(lane_en)
  );

  strobe_out_reg #(.LANES(LANES)) u_out (
    .clk(clk), .rst(rst), .active(active), .cs_lvl(cs_lvl), .bs_lvl(bs_lvl),
    .lane_en(lane_en), .g0_code(g0_code), .g0_addr(gpl_addr_bit),
    .g1_lvl(g1_lvl), .g2_lvl(g2_lvl), .cs_n(cs_n), .bs_n(bs_n), .gpl_n(gpl_n)
  );
endmodule

// File: rtl/strobe_phase_gen_chk.sv
module strobe_phase_gen_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic [1:0]       phase,
  input logic [31:0]      word,
  input logic [1:0]       port_size,
  input logic             cs_n,
  input logic [LANES-1:0] bs_n,
  input logic [2:0]       gpl_n
);
  // R1
  rst_negated_chk: assert property (@(posedge clk)
    rst |=> (cs_n && (&bs_n) && (&gpl_n)));

  // R8
  idle_negated_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cs_n && (&bs_n) && (&gpl_n)));

  // R2
  cs_first_quarter_chk: assert property (@(posedge clk) disable iff (rst)
    (active && phase == 2'd0) |=> (cs_n == $past(word[31])));

  // R4
  byte_port_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (active && port_size == 2'd2) |=> (&bs_n[LANES-1:1]));

  // R6
  gpl0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && phase != 2'd3 && word[23:22] == 2'b01) |=> $stable(gpl_n[0]));

  // R7
  gpl2_last_quarter_chk: assert property (@(posedge clk) disable iff (rst)
    (active && phase == 2'd3) |=> (gpl_n[2] == $past(word[16])));
endmodule

bind strobe_phase_gen strobe_phase_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .active(active), .phase(phase), .word(word),
  .port_size(port_size), .cs_n(cs_n), .bs_n(bs_n), .gpl_n(gpl_n)
);

// File: tb/strobe_phase_gen_test.sv
`timescale 1ns/1ps
module strobe_phase_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        active = 1'b0;
  logic [1:0]  phase = 2'd0;
  logic [31:0] word = 32'h0;
  logic [1:0]  port_size = 2'd0;
  logic [1:0]  xfer_size = 2'd0;
  logic [1:0]  addr_lo = 2'd0;
  logic        gpl_addr_bit = 1'b0;
  logic        cs_n;
  logic [3:0]  bs_n;
  logic [2:0]  gpl_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit       e_cs = 1'b1;
  bit [3:0] e_bs = 4'hF;
  bit [2:0] e_g  = 3'h7;
  string    ctx = "R1";

  always #2.5 clk = ~clk;

  strobe_phase_gen uut (
    .clk(clk), .rst(rst), .active(active), .phase(phase), .word(word),
    .port_size(port_size), .xfer_size(xfer_size), .addr_lo(addr_lo),
    .gpl_addr_bit(gpl_addr_bit), .cs_n(cs_n), .bs_n(bs_n), .gpl_n(gpl_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: computes next expected levels from the requirements
  task automatic model();
    int p, wdt, st, cnt, code;
    if (rst) begin
      e_cs = 1; e_bs = 4'hF; e_g = 3'h7; ctx = "R1";
    end else if (!active) begin
      e_cs = 1; e_bs = 4'hF; e_g = 3'h7; ctx = "R8";
    end else begin
      p = phase;
      ctx = "R9";
      e_cs = word[31 - p];
      wdt = (port_size == 1) ? 2 : (port_size == 2) ? 1 : 4;
      st  = addr_lo % wdt;
      cnt = xfer_size + 1;
      for (int i = 0; i < 4; i++)
        e_bs[i] = (i < wdt && i >= st && i < st + cnt) ? word[27 - p] : 1'b1;
      code = (p == 3) ? word[21:20] : word[23:22];
      case (code)
        2: e_g[0] = 1'b0;
        3: e_g[0] = 1'b1;
        0: e_g[0] = gpl_addr_bit;
        default: e_g[0] = e_g[0];
      endcase
      e_g[1] = (p == 3) ? word[18] : word[19];
      e_g[2] = (p == 3) ? word[16] : word[17];
    end
  endtask

  task automatic compare();
    if (ctx == "R9") begin
      chk("R2 R9 cs_n", cs_n, e_cs);
      chk("R3 R4 bs_n", bs_n, e_bs);
      chk("R5 R6 R7 gpl_n", gpl_n, e_g);
    end else begin
      chk({ctx, " all strobes"}, {cs_n, bs_n, gpl_n}, {e_cs, e_bs, e_g});
    end
  endtask

  task automatic step(input bit rs, input bit ac, input bit [1:0] ph,
                      input bit [31:0] w, input bit [1:0] ps, input bit [1:0] xs,
                      input bit [1:0] al, input bit ab);
    @(negedge clk);
    compare();
    rst = rs; active = ac; phase = ph; word = w;
    port_size = ps; xfer_size = xs; addr_lo = al; gpl_addr_bit = ab;
    model();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model();
    // R1: reset
    for (int i = 0; i < 3; i++) step(1, 1, 2'd0, 32'h0, 0, 3, 0, 0);
    // R8: idle with asserting words
    for (int i = 0; i < 4; i++) step(0, 0, 2'(i), 32'h0, 0, 3, 0, 0);
    // R2: chip-select per quarter, one bit cleared at a time
    for (int p = 0; p < 4; p++) step(0, 1, 2'(p), ~(32'h8000_0000 >> p), 0, 3, 0, 0);
    for (int p = 0; p < 4; p++) step(0, 1, 2'(p), (32'h8000_0000 >> p), 0, 3, 0, 0);
    // R3 R4: sweep port width, length and offset with byte-selects asserted
    for (int ps = 0; ps < 4; ps++)
      for (int xs = 0; xs < 4; xs++)
        for (int al = 0; al < 4; al++)
          step(0, 1, 2'(al), 32'h0, 2'(ps), 2'(xs), 2'(al), 0);
    // R5 R6: GPL0 codes chained so hold follows a known level
    step(0, 1, 2'd0, 32'hFFFF_FFFF & ~32'h0040_0000, 0, 0, 0, 0); // code 10 -> 0
    step(0, 1, 2'd1, 32'hFF7F_FFFF & ~32'h0080_0000 | 32'h0040_0000, 0, 0, 0, 0); // 01 hold
    step(0, 1, 2'd2, 32'h0040_0000, 0, 0, 0, 1); // hold
    step(0, 1, 2'd3, 32'h0030_0000, 0, 0, 0, 0); // quarter 4 code 11 -> 1
    step(0, 1, 2'd3, 32'h0010_0000, 0, 0, 0, 0); // quarter 4 hold
    step(0, 1, 2'd0, 32'h0000_0000, 0, 0, 0, 1); // addr copy 1
    step(0, 1, 2'd1, 32'h0000_0000, 0, 0, 0, 0); // addr copy 0
    step(0, 0, 2'd2, 32'h0040_0000, 0, 0, 0, 0); // R8 idle forces 1
    step(0, 1, 2'd2, 32'h0040_0000, 0, 0, 0, 0); // hold after idle -> 1
    // R7: GPL1 and GPL2 per quarter
    for (int p = 0; p < 4; p++) step(0, 1, 2'(p), 32'h0005_0000, 0, 0, 0, 0);
    for (int p = 0; p < 4; p++) step(0, 1, 2'(p), 32'h000A_0000, 0, 0, 0, 0);
    // Random run with occasional idle and reset
    for (int i = 0; i < 4000; i++)
      step(($urandom % 97) == 0, ($urandom % 8) != 0, 2'($urandom), $urandom,
           2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
    step(0, 0, 2'd0, 32'h0, 0, 0, 0, 0);
    step(0, 0, 2'd0, 32'h0, 0, 0, 0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule